// File: doc/BRIEF.md
# Nine-Bit Address-Mark Receive Filter

This block follows a nine-bit serial receiver on a shared multi-drop line and decides which received characters reach the local consumer. Each incoming character carries eight payload bits plus a mark bit in position 8: a mark of 1 flags an address character and a mark of 0 flags payload data. The filter holds one of two named states, LISTEN and SELECTED, and forwards payload only while it is SELECTED.

An address character is compared with the node address. Bits set in the mask are treated as don't-care, and the all-ones address 0xFF is always accepted as a broadcast. A hit moves the filter to SELECTED (transition LISTEN->SELECTED, or SELECTED->SELECTED on a repeated hit). A miss moves it to LISTEN (SELECTED->LISTEN, or LISTEN->LISTEN). Characters flagged with a parity or framing error are dropped without any transition. When the filter is disabled it passes every error-free character and is held in LISTEN.

Top module: `addr_mark_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and selected is 0 (state LISTEN).
- R2: An error-free address character (in_char[8]=1) whose low byte equals cfg_node_id on every bit where cfg_dont_care is 0 sets selected to 1 in the cycle after it is accepted.
- R3: An error-free address character with low byte 0xFF sets selected to 1 whatever cfg_node_id and cfg_dont_care hold.
- R4: While selected is 1, an error-free data character (in_char[8]=0) appears on out_data with out_valid=1 in the cycle after it is accepted; selected stays 1.
- R5: While selected is 0 and the filter is enabled, a data character produces no out_valid and leaves selected at 0.
- R6: An enabled, error-free address character that does not hit (neither R2 nor R3) makes selected 0 in the next cycle, from either state.
- R7: While enabled, an address character never produces out_valid.
- R8: A character with in_err=1 produces no out_valid and leaves selected unchanged.
- R9: With cfg_enable=0, every error-free character, whatever its mark bit, is forwarded with its low byte one cycle later, and selected reads 0 one cycle after cfg_enable is 0.
- R10: Address bits whose cfg_dont_care bit is 1 take no part in the comparison of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received character is present this cycle |
| in_char | input | 9 | Received character; bit 8 is the address mark |
| in_err | input | 1 | Parity or framing error on this character |
| cfg_enable | input | 1 | 1 = filtering active, 0 = pass everything |
| cfg_node_id | input | 8 | Node address |
| cfg_dont_care | input | 8 | Address bits excluded from comparison |
| out_valid | output | 1 | A payload byte is delivered |
| out_data | output | 8 | Delivered payload byte |
| selected | output | 1 | 1 while the state is SELECTED |

## Verification
Both results are due exactly one rising edge after the character is accepted: out_valid and out_data come from a register loaded at that edge, and selected reflects the state register that is updated at the same edge, so a data character following an address character is already judged against the new state. The bench drives each character at a falling edge, waits for the next rising edge and samples 1 ns later, before any further input changes. It then clears in_valid, so every expectation depends on one character only. The address sweep walks all 256 low-byte values under several node-address and mask settings and follows each value with a data character, which also exercises SELECTED->LISTEN on misses.

// File: rtl/afl_pkg.sv
package afl_pkg;
    typedef enum logic {
        ST_LISTEN   = 1'b0,
        ST_SELECTED = 1'b1
    } afl_state_t;
endpackage

// File: rtl/afl_match.sv
module afl_match #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] id_in,
    input  logic [ID_W-1:0] node_id,
    input  logic [ID_W-1:0] dont_care,
    output logic            hit
);
    logic masked_eq;
    logic bcast;

    always_comb begin
        masked_eq = (((id_in ^ node_id) & ~dont_care) == '0);
        bcast     = &id_in;
        hit       = masked_eq | bcast;
    end
endmodule

// File: rtl/afl_fsm.sv
module afl_fsm
    import afl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       char_ok,
    input  logic       is_addr,
    input  logic       hit,
    output afl_state_t state
);
    afl_state_t nxt;

    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_LISTEN;
        end else if (char_ok && is_addr) begin
            unique case (state)
                ST_LISTEN:   nxt = hit ? ST_SELECTED : ST_LISTEN;
                ST_SELECTED: nxt = hit ? ST_SELECTED : ST_LISTEN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LISTEN;
        else        state <= nxt;
    end

    // R6
    miss_to_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && char_ok && is_addr && !hit) |=> (state == ST_LISTEN));

    // R2
    hit_to_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && char_ok && is_addr && hit) |=> (state == ST_SELECTED));

    // R9
    disabled_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_LISTEN));
endmodule

// File: rtl/addr_mark_filter.sv
module addr_mark_filter
    import afl_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W:0]   in_char,
    input  logic              in_err,
    input  logic              cfg_enable,
    input  logic [DATA_W-1:0] cfg_node_id,
    input  logic [DATA_W-1:0] cfg_dont_care,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              selected
);
    localparam int MARK_POS = DATA_W;

    logic              char_ok;
    logic              is_addr;
    logic              hit;
    logic              fwd;
    logic [DATA_W-1:0] payload;
    afl_state_t        state;

    assign char_ok = in_valid && !in_err;
    assign is_addr = in_char[MARK_POS];
    assign payload = in_char[DATA_W-1:0];

    afl_match #(.ID_W(DATA_W)) i_match (
        .id_in     (payload),
        .node_id   (cfg_node_id),
        .dont_care (cfg_dont_care),
        .hit       (hit)
    );

    afl_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (cfg_enable),
        .char_ok (char_ok),
        .is_addr (is_addr),
        .hit     (hit),
        .state   (state)
    );

    always_comb begin
        fwd = 1'b0;
        if (char_ok) begin
            if (!cfg_enable) fwd = 1'b1;
            else             fwd = !is_addr && (state == ST_SELECTED);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= fwd;
            if (fwd) out_data <= payload;
        end
    end

    assign selected = (state == ST_SELECTED);

    // R7
    addr_not_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && in_valid && in_char[MARK_POS]) |=> !out_valid);

    // R8
    err_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_err) |=> (!out_valid && $stable(selected)));

    // R5
    listen_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !selected && in_valid && !in_char[MARK_POS]) |=> (!out_valid && !selected));

    // R4
    sel_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && selected && in_valid && !in_err && !in_char[MARK_POS])
        |=> (out_valid && selected && out_data == $past(in_char[DATA_W-1:0])));
endmodule

// File: tb/test_addr_mark_filter.sv
module test_addr_mark_filter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [8:0] in_char;
    logic       in_err;
    logic       cfg_enable;
    logic [7:0] cfg_node_id;
    logic [7:0] cfg_dont_care;
    logic       out_valid;
    logic [7:0] out_data;
    logic       selected;

    int total = 0;
    int bad   = 0;
    logic exp_sel = 1'b0;

    always #4 clk = ~clk;

    addr_mark_filter i_addr_mark_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_char       (in_char),
        .in_err        (in_err),
        .cfg_enable    (cfg_enable),
        .cfg_node_id   (cfg_node_id),
        .cfg_dont_care (cfg_dont_care),
        .out_valid     (out_valid),
        .out_data      (out_data),
        .selected      (selected)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Send one character, check results one edge later.
    task automatic step(input logic mark, input logic [7:0] b, input logic err);
        logic hitv;
        logic exp_v;
        string tag;
        hitv = ((((b ^ cfg_node_id) & ~cfg_dont_care) == 8'h00) || (b == 8'hFF));
        exp_v = 1'b0;
        if (err) begin
            tag = "R8";
        end else if (!cfg_enable) begin
            tag = "R9"; exp_v = 1'b1; exp_sel = 1'b0;
        end else if (mark) begin
            exp_sel = hitv;
            if (!hitv)            tag = "R6 R7";
            else if (b == 8'hFF)  tag = "R3 R7";
            else if (cfg_dont_care != 0) tag = "R10 R7";
            else                  tag = "R2 R7";
        end else if (exp_sel) begin
            tag = "R4"; exp_v = 1'b1;
        end else begin
            tag = "R5";
        end
        @(negedge clk);
        in_valid = 1'b1; in_char = {mark, b}; in_err = err;
        @(posedge clk);
        #1;
        chk(out_valid == exp_v, tag, out_valid, exp_v);
        if (exp_v) chk(out_data == b, tag, out_data, b);
        chk(selected == exp_sel, tag, selected, exp_sel);
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_char = '0; in_err = 1'b0;
        cfg_enable = 1'b1; cfg_node_id = 8'h35; cfg_dont_care = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(selected == 1'b0, "R1", selected, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(selected == 1'b0, "R1", selected, 0);

        // R5: data while listening
        step(1'b0, 8'h55, 1'b0);
        step(1'b0, 8'hAA, 1'b0);

        // Address sweeps with several masks (R2 R3 R4 R6 R7 R10)
        for (int cfg = 0; cfg < 3; cfg++) begin
            case (cfg)
                0: begin cfg_node_id = 8'h35; cfg_dont_care = 8'h00; end
                1: begin cfg_node_id = 8'h35; cfg_dont_care = 8'h0F; end
                default: begin cfg_node_id = 8'hA0; cfg_dont_care = 8'hF0; end
            endcase
            for (int v = 0; v < 256; v++) begin
                step(1'b1, v[7:0], 1'b0);
                step(1'b0, v[7:0] ^ 8'h5A, 1'b0);
            end
        end

        // R8: errors in both states
        cfg_node_id = 8'h12; cfg_dont_care = 8'h00;
        step(1'b1, 8'h12, 1'b0);
        step(1'b1, 8'h77, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        step(1'b0, 8'hFF, 1'b0);
        step(1'b1, 8'h44, 1'b0);
        step(1'b1, 8'h12, 1'b1);
        step(1'b0, 8'h3C, 1'b0);

        // R9: disable while selected, then pass-through
        step(1'b1, 8'h12, 1'b0);
        @(negedge clk); cfg_enable = 1'b0;
        @(posedge clk); #1;
        exp_sel = 1'b0;
        chk(selected == 1'b0, "R9", selected, 0);
        step(1'b1, 8'h99, 1'b0);
        step(1'b0, 8'h00, 1'b0);
        step(1'b1, 8'h12, 1'b0);
        step(1'b0, 8'hC3, 1'b1);
        @(negedge clk); cfg_enable = 1'b1;
        step(1'b0, 8'h81, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule